// File: doc/BRIEF.md
# Level-Flag Parity FIFO

This block is a single-clock first-in first-out buffer for 9-bit words. The
storage holds up to 256 words. A 3-bit depth code, captured while reset is
held, picks a power-of-two usable depth from 2 to 256 words. Writes and reads
are requested with active-low strobes. Each strobe only counts when its own
active-low select is also low. Full blocks writes and empty blocks reads.

Two level flags compare the number of stored words with an 8-bit level input.
One is high when the count equals the level. The other is high when the count
is at least the level. Bit 8 of each word is a parity bit, and a polarity input
picks even or odd parity. A build parameter decides how that bit is handled:

- **Generation on:** the block computes bit 8 itself on the way in.
- **Generation off:** the block only checks the incoming bit 8 and reports a
  write parity error on a mismatch.

On the way out, the stored parity is checked against the stored payload, and a
mismatch raises a read parity error.

Occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| `ST_EMPTY` | nothing stored |
| `ST_PARTIAL` | between one word and one short of the depth |
| `ST_FULL` | the count equals the depth |

The transitions are:

- **`FILL_FIRST`** (`ST_EMPTY` to `ST_PARTIAL`): an accepted write.
- **`FILL_LAST`** (`ST_PARTIAL` to `ST_FULL`): a write alone at depth minus one.
- **`DRAIN_LAST`** (`ST_PARTIAL` to `ST_EMPTY`): a read alone at count one.
- **`DRAIN_FIRST`** (`ST_FULL` to `ST_PARTIAL`): an accepted read.

Every other cycle holds the state.

Top module: `lvl_parity_fifo`

## Requirements
- R1: A clock edge with `rst_n` low clears the pointers and the count. Afterwards `empty`=1, `full`=0, `wr_perr`=0, `rd_perr`=0 and `dout`=0.
- R2: The usable depth is 2^(d+1) words, where d is the value of `depth_code` sampled while `rst_n` is low. A change of `depth_code` after reset has no effect. `full` rises after exactly that many accepted writes.
- R3: A write is requested only when `wr_n`=0 and `wr_sel_n`=0. A read is requested only when `rd_n`=0 and `rd_sel_n`=0. Any other combination leaves the stored contents and `dout` unchanged.
- R4: While `full`=1 a write request is ignored. While `empty`=1 a read request is ignored and `dout` holds. Words leave in the order they were accepted, and `full` and `empty` are never both high.
- R5: `lvl_eq`=1 exactly when the stored count equals `level`. `lvl_ge`=1 exactly when the count is greater than or equal to `level`, and a count of 256 is above every level.
- R6: Read data is registered. The word appears on `dout` in the cycle after the edge that accepted the read, and it holds until the next accepted read.
- R7: With `GEN_PARITY`=1, bit 8 is replaced on write. With `par_odd`=0 it is the XOR of bits 7:0; with `par_odd`=1 it is the inverse of that XOR. In this mode `wr_perr` stays 0.
- R8: With `GEN_PARITY`=0, `wr_perr` is 1 for one cycle after an accepted write whose bit 8 differs from the parity of bits 7:0 selected by `par_odd`.
- R9: `rd_perr` is 1 in the cycle that read data becomes valid, only if the stored bit 8 differs from the parity of the stored bits 7:0 under the current `par_odd`. It is 0 in every other cycle.
- R10: An accepted write and an accepted read in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low; captures `depth_code` |
| depth_code | input | 3 | Depth select d, depth = 2^(d+1) |
| wr_n | input | 1 | Write strobe, active low |
| wr_sel_n | input | 1 | Write select, active low |
| rd_n | input | 1 | Read strobe, active low |
| rd_sel_n | input | 1 | Read select, active low |
| level | input | 8 | Occupancy level for comparison |
| par_odd | input | 1 | Parity polarity: 0 even, 1 odd |
| din | input | 9 | Write word, bit 8 is parity |
| dout | output | 9 | Registered read word |
| full | output | 1 | Count equals depth |
| empty | output | 1 | Count is zero |
| lvl_eq | output | 1 | Count equals `level` |
| lvl_ge | output | 1 | Count at least `level` |
| wr_perr | output | 1 | Write parity error, active high |
| rd_perr | output | 1 | Read parity error, active high |

## Verification
The assertions check a set of rules on every cycle:
- The count never passes the depth.
- `full` and `empty` are never high together.
- A blocked write or read leaves the flag state in place.
- A mixed read and write keeps the count.
- The equal flag implies the at-least flag.
- A read parity error is only ever seen after an accepted read.

Other behaviour can only be shown by the bench's scenarios. These are:
- first-in first-out ordering and the generated parity values, which the scoreboard checks;
- the exact depth for several depth codes, and that a late change of the code is ignored;
- gating by the select inputs;
- the count of 256 against level 0;
- error pulses on words with bad parity, both from the build without generation and after the polarity changes.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/fifo_occupancy.sv
module fifo_occupancy
    import fifo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 3,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] depth_code,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    occ_state_t state, state_nx;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  depth_words;
    logic [ADDR_W-1:0] ptr_mask;

    // depth = 2^(code+1), clamped to the storage size
    always_comb begin
        if (32'(code_q) + 1 >= ADDR_W)
            depth_words = CNT_W'(1) << ADDR_W;
        else
            depth_words = CNT_W'(1) << (32'(code_q) + 1);
        ptr_mask = ADDR_W'(depth_words - CNT_W'(1));
    end

    assign wr_ok = wr_req && (state != ST_FULL);
    assign rd_ok = rd_req && (state != ST_EMPTY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY:   if (wr_ok) state_nx = ST_PARTIAL;                // FILL_FIRST
            ST_PARTIAL: begin
                if (wr_ok && !rd_ok && count == depth_words - CNT_W'(1))
                    state_nx = ST_FULL;                                   // FILL_LAST
                else if (rd_ok && !wr_ok && count == CNT_W'(1))
                    state_nx = ST_EMPTY;                                  // DRAIN_LAST
            end
            ST_FULL:    if (rd_ok) state_nx = ST_PARTIAL;                // DRAIN_FIRST
            default:    state_nx = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full  = (state == ST_FULL);
        empty = (state == ST_EMPTY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= depth_code;
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr + ADDR_W'(1)) & ptr_mask;
            if (rd_ok) rptr <= (rptr + ADDR_W'(1)) & ptr_mask;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth_words);                                            // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));                                                // R4
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> full);                            // R4
    AST_EMPTY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> empty);                          // R4
    AST_MIXED_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> $stable(count));                             // R10

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wptr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] rptr,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_vld
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_ok;
            if (rd_ok) rdata <= mem[rptr];
        end
    end

endmodule

// File: rtl/fifo_parity.sv
module fifo_parity #(
    parameter int DATA_W     = 8,
    parameter bit GEN_PARITY = 1'b1,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_odd,
    input  logic [WORD_W-1:0] din,
    input  logic              wr_ok,
    output logic [WORD_W-1:0] wr_word,
    output logic              wr_perr,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              rd_vld,
    output logic              rd_perr
);

    function automatic logic pbit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    logic wr_bad;

    generate
        if (GEN_PARITY) begin : g_gen
            assign wr_word = {pbit(din[DATA_W-1:0], par_odd), din[DATA_W-1:0]};
            assign wr_bad  = 1'b0;
        end else begin : g_chk
            assign wr_word = din;
            assign wr_bad  = din[DATA_W] != pbit(din[DATA_W-1:0], par_odd);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) wr_perr <= 1'b0;
        else        wr_perr <= wr_ok && wr_bad;
    end

    assign rd_perr = rd_vld && (rd_word[DATA_W] != pbit(rd_word[DATA_W-1:0], par_odd));

    generate
        if (GEN_PARITY) begin : g_gen_chk
            always_comb begin
                if (rst_n) AST_GEN_NO_WPERR: assert (!wr_perr);           // R7
            end
        end
    endgenerate

endmodule

// File: rtl/lvl_parity_fifo.sv
module lvl_parity_fifo #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int CODE_W     = 3,
    parameter bit GEN_PARITY = 1'b1,
    localparam int WORD_W = DATA_W + 1,
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] depth_code,
    input  logic              wr_n,
    input  logic              wr_sel_n,
    input  logic              rd_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] level,
    input  logic              par_odd,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              lvl_eq,
    output logic              lvl_ge,
    output logic              wr_perr,
    output logic              rd_perr
);

    logic              wr_req, rd_req, wr_ok, rd_ok, rd_vld;
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] wr_word;

    assign wr_req = !wr_n && !wr_sel_n;
    assign rd_req = !rd_n && !rd_sel_n;

    fifo_occupancy #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_occ (
        .clk, .rst_n, .depth_code, .wr_req, .rd_req,
        .wr_ok, .rd_ok, .wptr, .rptr, .count, .full, .empty
    );

    fifo_parity #(.DATA_W(DATA_W), .GEN_PARITY(GEN_PARITY)) u_par (
        .clk, .rst_n, .par_odd, .din, .wr_ok, .wr_word, .wr_perr,
        .rd_word(dout), .rd_vld, .rd_perr
    );

    fifo_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk, .rst_n, .wr_ok, .wptr, .wdata(wr_word),
        .rd_ok, .rptr, .rdata(dout), .rd_vld
    );

    assign lvl_eq = (count == {1'b0, level});
    assign lvl_ge = (count >= {1'b0, level});

    AST_EQ_IMPLIES_GE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_eq |-> lvl_ge);                                               // R5
    AST_RD_PERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_perr |-> $past(rd_req && !empty));                             // R9

endmodule

// File: tb/tb_lvl_parity_fifo.sv
`timescale 1ns/1ps
module tb_lvl_parity_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] depth_code = 3'd1;
    logic       wr_n = 1'b1, wr_sel_n = 1'b1, rd_n = 1'b1, rd_sel_n = 1'b1;
    logic [7:0] level = 8'd0;
    logic       par_odd = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout, raw_dout;
    logic full, empty, lvl_eq, lvl_ge, wr_perr, rd_perr;
    logic raw_full, raw_empty, raw_eq, raw_ge, raw_wr_perr, raw_rd_perr;

    always #2.5 clk = ~clk;

    lvl_parity_fifo dut (
        .clk, .rst_n, .depth_code, .wr_n, .wr_sel_n, .rd_n, .rd_sel_n,
        .level, .par_odd, .din, .dout, .full, .empty, .lvl_eq, .lvl_ge,
        .wr_perr, .rd_perr
    );

    lvl_parity_fifo #(.GEN_PARITY(1'b0)) dut_raw (
        .clk, .rst_n, .depth_code, .wr_n, .wr_sel_n, .rd_n, .rd_sel_n,
        .level, .par_odd, .din, .dout(raw_dout), .full(raw_full),
        .empty(raw_empty), .lvl_eq(raw_eq), .lvl_ge(raw_ge),
        .wr_perr(raw_wr_perr), .rd_perr(raw_rd_perr)
    );

    int checks = 0, errors = 0;
    int mcount = 0, mdepth = 4;
    logic [8:0] q[$];
    logic       mon_arm = 1'b0;
    logic [8:0] mon_exp = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] gen(input logic [8:0] d, input logic odd);
        return {(^d[7:0]) ^ odd, d[7:0]};
    endfunction

    // monitor: compares each read word against the scoreboard
    always @(negedge clk) begin
        if (mon_arm) chk(dout === mon_exp, "R6 R7 R4 scoreboard dout", 32'(dout), 32'(mon_exp));
    end

    task automatic rst(input logic [2:0] d);
        mon_arm = 1'b0;
        rst_n = 1'b0; depth_code = d;
        wr_n = 1'b1; wr_sel_n = 1'b1; rd_n = 1'b1; rd_sel_n = 1'b1;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        mdepth = 2 << d; mcount = 0; q.delete();
    endtask

    // driver: one cycle of stimulus, predicted acceptance pushed to the queue
    task automatic op(input bit w, input bit ws, input bit r, input bit rs, input logic [8:0] d);
        bit wacc, racc;
        wr_n = !w; wr_sel_n = !ws; rd_n = !r; rd_sel_n = !rs; din = d;
        wacc = w && ws && (mcount < mdepth);
        racc = r && rs && (mcount > 0);
        if (wacc) q.push_back(gen(d, par_odd));
        mcount = mcount + int'(wacc) - int'(racc);
        @(posedge clk); #1;
        mon_arm = racc;
        if (racc) mon_exp = q.pop_front();
        @(negedge clk);
        wr_n = 1'b1; wr_sel_n = 1'b1; rd_n = 1'b1; rd_sel_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] held;
        rst(3'd1);
        // R1 reset state
        chk(empty == 1'b1 && full == 1'b0, "R1 flags", {full, empty}, 32'b01);
        chk(wr_perr == 1'b0 && rd_perr == 1'b0, "R1 errors", {wr_perr, rd_perr}, 0);
        chk(dout == 9'h000, "R1 dout", 32'(dout), 0);

        depth_code = 3'd7;                          // R2: ignored outside reset
        op(1, 0, 0, 0, 9'h0AA);                     // R3: write without select
        chk(empty == 1'b1, "R3 unselected write", 32'(empty), 1);

        level = 8'd3;
        for (int i = 0; i < 4; i++) begin
            op(1, 1, 0, 0, 9'(8'h10 + i));
            if (i == 2) chk(lvl_eq && lvl_ge, "R5 count3 level3", {lvl_eq, lvl_ge}, 32'b11);
        end
        chk(full == 1'b1, "R2 full after 4 writes", 32'(full), 1);
        chk(!lvl_eq && lvl_ge, "R5 count4 level3", {lvl_eq, lvl_ge}, 32'b01);
        op(1, 1, 0, 0, 9'h0FF);                     // R4 blocked write
        chk(full == 1'b1, "R4 write on full", 32'(full), 1);
        op(0, 0, 1, 0, 9'h000);                     // R3 read without select
        chk(full == 1'b1, "R3 unselected read", 32'(full), 1);
        op(0, 0, 1, 1, 9'h000);
        chk(full == 1'b0, "R4 full clears", 32'(full), 0);
        held = dout;
        op(0, 0, 0, 0, 9'h000);
        chk(dout == held, "R6 dout holds", 32'(dout), 32'(held));
        op(1, 1, 1, 1, 9'h055);                     // R10 mixed at count 3
        chk(lvl_eq == 1'b1, "R10 count kept", 32'(lvl_eq), 1);
        for (int i = 0; i < 3; i++) op(0, 0, 1, 1, 9'h000);
        chk(empty == 1'b1, "R4 empty after drain", 32'(empty), 1);
        held = dout;
        op(0, 0, 1, 1, 9'h000);
        chk(dout == held && empty, "R4 read on empty", 32'(dout), 32'(held));

        // R7 odd parity generation
        par_odd = 1'b1;
        op(1, 1, 0, 0, 9'h003);
        op(1, 1, 0, 0, 9'h0F0);
        op(0, 0, 1, 1, 9'h000);
        chk(rd_perr == 1'b0, "R9 clean read", 32'(rd_perr), 0);
        op(0, 0, 1, 1, 9'h000);
        chk(dout == 9'h1F0, "R7 odd parity bit", 32'(dout), 32'h1F0);

        // R9 polarity flip between write and read
        par_odd = 1'b0;
        op(1, 1, 0, 0, 9'h007);
        par_odd = 1'b1;
        op(0, 0, 1, 1, 9'h000);
        chk(rd_perr == 1'b1, "R9 rd_perr pulse", 32'(rd_perr), 1);
        op(0, 0, 0, 0, 9'h000);
        chk(rd_perr == 1'b0, "R9 rd_perr one cycle", 32'(rd_perr), 0);

        // R8 check-only build
        par_odd = 1'b0;
        op(1, 1, 0, 0, 9'h001);
        chk(raw_wr_perr == 1'b1, "R8 bad parity write", 32'(raw_wr_perr), 1);
        chk(wr_perr == 1'b0, "R7 no wr_perr when generating", 32'(wr_perr), 0);
        op(1, 1, 0, 0, 9'h101);
        chk(raw_wr_perr == 1'b0, "R8 good parity write", 32'(raw_wr_perr), 0);
        op(0, 0, 1, 1, 9'h000);
        chk(raw_rd_perr == 1'b1 && raw_dout == 9'h001, "R9 raw bad read", 32'(raw_dout), 32'h001);
        op(0, 0, 1, 1, 9'h000);
        chk(raw_rd_perr == 1'b0 && raw_dout == 9'h101, "R9 raw good read", 32'(raw_dout), 32'h101);

        // R2 / R5 depth 256
        rst(3'd7);
        level = 8'd255;
        for (int i = 0; i < 255; i++) op(1, 1, 0, 0, 9'(i));
        chk(full == 1'b0 && lvl_eq == 1'b1, "R2 255 of 256", {full, lvl_eq}, 32'b01);
        op(1, 1, 0, 0, 9'h0C3);
        chk(full == 1'b1, "R2 full at 256", 32'(full), 1);
        level = 8'd0;
        #1;
        chk(!lvl_eq && lvl_ge, "R5 count256 level0", {lvl_eq, lvl_ge}, 32'b01);
        for (int i = 0; i < 256; i++) op(0, 0, 1, 1, 9'h000);
        chk(empty == 1'b1, "R4 drained 256", 32'(empty), 1);

        // R2 minimum depth
        rst(3'd0);
        op(1, 1, 0, 0, 9'h011);
        chk(full == 1'b0, "R2 depth2 one word", 32'(full), 0);
        op(1, 1, 0, 0, 9'h022);
        chk(full == 1'b1, "R2 depth2 full", 32'(full), 1);

        mon_arm = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule